// File: doc/BRIEF.md
# B3ZS/HDB3 Zero-Substitution Line Encoder

This block turns a serial NRZ bit stream into the two logic rails of an alternate-mark-inversion (AMI) line signal, one symbol per accepted beat. Every mark becomes a pulse of the opposite polarity to the previous pulse. Runs of zeros are replaced by a pattern that contains a deliberate bipolar violation, so that the line always carries enough transitions for clock recovery. Three-zero substitution is used at the DS3 and STS-1 rates, and four-zero substitution at the E3 rate. The rate is selected on a static mode input.

A bypass input switches the encoding off. The two transmit inputs are then taken to be already-encoded positive and negative rails, and they travel through the same pipeline without change. Bits enter on a valid/ready stream and symbols leave on a valid/ready stream. The pipeline moves only when an input beat is accepted. An input beat is accepted when `in_valid` is high and `in_ready` is high, and `in_ready` is high whenever the output register is empty or is being taken in the same cycle. An output symbol that is offered and not taken stays unchanged until `out_ready` rises. A parameter selects which clock edge clocks every register. `line_mode` and `enc_bypass` may only be changed while reset is applied.

Top module: `b3zs_hdb3_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, both rails are 0, the last pulse polarity is taken as negative and the pulse parity is even.
- R2: With encoding on, a mark (`tx_data`=1) gives a pulse of the opposite polarity to the previous pulse, so the first pulse after reset is positive. A positive pulse is `out_pos`=1, `out_neg`=0, a negative pulse is `out_pos`=0, `out_neg`=1, and a zero has both rails at 0.
- R3: When `line_mode` is 2'b00 (DS3), 2'b10 (STS-1) or 2'b11, each run of three zeros is replaced by 0,0,V if an odd number of pulses has been sent since the last V, and by B,0,V if that number is even.
- R4: When `line_mode` is 2'b01 (E3), each run of four zeros is replaced by 0,0,0,V if the pulse count since the last V is odd, and by B,0,0,V if it is even.
- R5: A V pulse has the same polarity as the pulse before it, a B pulse follows the alternation rule, and the pulse count restarts at zero after each V.
- R6: With encoding on, `tx_aux` has no effect on the output.
- R7: With `enc_bypass`=1, `tx_data` and `tx_aux` appear unchanged on `out_pos` and `out_neg`, both rails may be high together, and the latency is the same as in encoding mode.
- R8: A symbol accepted on a beat appears in the output register on the beat that accepts the symbol three beats later (B3ZS) or four beats later (HDB3). An offered symbol that is taken while no new input is accepted leaves `out_valid` low.
- R9: While `out_valid`=1 and `out_ready`=0, the output symbol stays unchanged, `in_ready` is 0, and no symbol is lost or repeated.
- R10: With parameter `TX_CLK_INV`=1, all registers update on the falling edge of `clk`.
- R11: With encoding on, the output never carries more zeros in a row than the substitution length minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_mode | input | 2 | 2'b01 E3 (HDB3). Any other value is DS3/STS-1 (B3ZS) |
| enc_bypass | input | 1 | 1: forward dual-rail inputs unchanged |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be accepted |
| tx_data | input | 1 | NRZ data, or positive rail in bypass |
| tx_aux | input | 1 | Negative rail in bypass, ignored otherwise |
| out_valid | output | 1 | Output symbol offered |
| out_ready | input | 1 | Sink takes the output symbol |
| out_pos | output | 1 | Positive AMI rail |
| out_neg | output | 1 | Negative AMI rail |

## Verification
A bit accepted at one edge is due on the rails after the edge that accepts the bit three beats later (B3ZS) or four beats later (HDB3). The offered symbol is then taken at the first edge where `out_ready` is high. The scoreboard therefore keys its comparisons on handshakes and not on elapsed cycles. It samples `out_valid`, `out_ready` and the rails half a period before the edge that takes the symbol. Because of this fixed lag, exactly three or four expected symbols must stay unmatched once the input stops, and the bench checks that count. The direct latency probe and the falling-edge variant are sampled a few nanoseconds after the edge on which the change is due.

// File: rtl/zs_pkg.sv
package zs_pkg;

  // Symbol held in each pipeline slot; its polarity is decided at the output.
  typedef enum logic [2:0] {
    SYM_ZERO   = 3'd0,
    SYM_MARK   = 3'd1,
    SYM_BPULSE = 3'd2,
    SYM_VPULSE = 3'd3,
    SYM_RAW_P  = 3'd4,
    SYM_RAW_N  = 3'd5,
    SYM_RAW_PN = 3'd6
  } sym_e;

  typedef struct packed {
    logic vld;
    sym_e sym;
  } slot_t;

  localparam logic [1:0] RATE_E3 = 2'b01;

endpackage

// File: rtl/zs_slot_line.sv
module zs_slot_line
  import zs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  slot_t                   in_slot,
  input  logic [DEPTH-1:0]        ovr_en,
  input  sym_e  [DEPTH-1:0]       ovr_sym,
  output slot_t [DEPTH-1:0]       shifted,
  output slot_t [DEPTH-1:0]       stage
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign shifted[i] = in_slot;
    end else begin : g_body
      assign shifted[i] = stage[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[i] <= '{vld: 1'b0, sym: SYM_ZERO};
      end else if (adv) begin
        if (ovr_en[i]) stage[i] <= '{vld: shifted[i].vld, sym: ovr_sym[i]};
        else           stage[i] <= shifted[i];
      end
    end
  end

endmodule

// File: rtl/zs_run_detect.sv
module zs_run_detect
  import zs_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 4
) (
  input  slot_t [DEPTH-1:0] win,
  input  logic              long_sel,
  input  logic              enable,
  input  logic              parity_odd,
  output logic [DEPTH-1:0]  ovr_en,
  output sym_e  [DEPTH-1:0] ovr_sym
);

  logic [DEPTH-1:0] zero_ok;
  logic             hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    localparam bit IN_SHORT  = (i < SHORT_RUN);
    localparam bit IN_LONG   = (i < LONG_RUN);
    localparam bit TAIL_S    = (i == SHORT_RUN - 1);
    localparam bit TAIL_L    = (i == LONG_RUN - 1);
    logic in_win;
    logic is_tail;

    assign in_win  = long_sel ? IN_LONG : IN_SHORT;
    assign is_tail = long_sel ? TAIL_L : TAIL_S;
    assign zero_ok[i] = !in_win || (win[i].vld && (win[i].sym == SYM_ZERO));

    if (i == 0) begin : g_newest
      // Newest slot of a completed run always carries the violation.
      assign ovr_en[i]  = hit;
      assign ovr_sym[i] = SYM_VPULSE;
    end else begin : g_older
      // Oldest slot becomes a balancing pulse when parity is even.
      assign ovr_en[i]  = hit && is_tail && !parity_odd;
      assign ovr_sym[i] = SYM_BPULSE;
    end
  end

  assign hit = enable && (&zero_ok);

endmodule

// File: rtl/zs_pulse_former.sv
module zs_pulse_former
  import zs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  out_ready,
  input  slot_t leave,
  output logic  parity_odd_nx,
  output logic  out_valid,
  output logic  out_pos,
  output logic  out_neg
);

  logic last_pol;   // 1 = last pulse positive
  logic par_odd;
  logic pol_nx, par_nx, pos_c, neg_c;

  always_comb begin
    pol_nx = last_pol;
    par_nx = par_odd;
    pos_c  = 1'b0;
    neg_c  = 1'b0;
    if (leave.vld) begin
      unique case (leave.sym)
        SYM_MARK, SYM_BPULSE: begin
          pol_nx = ~last_pol;
          par_nx = ~par_odd;
          pos_c  = ~last_pol;
          neg_c  = last_pol;
        end
        SYM_VPULSE: begin
          pos_c  = last_pol;
          neg_c  = ~last_pol;
          par_nx = 1'b0;
        end
        SYM_RAW_P:  pos_c = 1'b1;
        SYM_RAW_N:  neg_c = 1'b1;
        SYM_RAW_PN: begin
          pos_c = 1'b1;
          neg_c = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign parity_odd_nx = par_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pol  <= 1'b0;
      par_odd   <= 1'b0;
      out_valid <= 1'b0;
      out_pos   <= 1'b0;
      out_neg   <= 1'b0;
    end else if (adv) begin
      last_pol  <= pol_nx;
      par_odd   <= par_nx;
      out_valid <= leave.vld;
      out_pos   <= pos_c;
      out_neg   <= neg_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/b3zs_hdb3_encoder.sv
module b3zs_hdb3_encoder
  import zs_pkg::*;
#(
  parameter int SHORT_RUN  = 3,
  parameter int LONG_RUN   = 4,
  parameter bit TX_CLK_INV = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_mode,
  input  logic       enc_bypass,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       tx_data,
  input  logic       tx_aux,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_pos,
  output logic       out_neg
);

  localparam int DEPTH = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;

  logic             edge_clk;
  logic             long_sel;
  logic             adv;
  logic             parity_odd_nx;
  slot_t            in_slot;
  slot_t            leave;
  slot_t [DEPTH-1:0] shifted;
  slot_t [DEPTH-1:0] stage;
  logic  [DEPTH-1:0] ovr_en;
  sym_e  [DEPTH-1:0] ovr_sym;

  if (TX_CLK_INV) begin : g_fall
    assign edge_clk = ~clk;
  end else begin : g_rise
    assign edge_clk = clk;
  end

  assign long_sel = (line_mode == RATE_E3);
  assign in_ready = out_ready || !out_valid;
  assign adv      = in_valid && in_ready;
  assign leave    = long_sel ? stage[LONG_RUN-1] : stage[SHORT_RUN-1];

  always_comb begin
    in_slot.vld = 1'b1;
    if (enc_bypass) begin
      unique case ({tx_data, tx_aux})
        2'b10:   in_slot.sym = SYM_RAW_P;
        2'b01:   in_slot.sym = SYM_RAW_N;
        2'b11:   in_slot.sym = SYM_RAW_PN;
        default: in_slot.sym = SYM_ZERO;
      endcase
    end else begin
      in_slot.sym = tx_data ? SYM_MARK : SYM_ZERO;
    end
  end

  zs_slot_line #(.DEPTH(DEPTH)) u_line (
    .clk     (edge_clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_slot (in_slot),
    .ovr_en  (ovr_en),
    .ovr_sym (ovr_sym),
    .shifted (shifted),
    .stage   (stage)
  );

  zs_run_detect #(.DEPTH(DEPTH), .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_detect (
    .win        (shifted),
    .long_sel   (long_sel),
    .enable     (!enc_bypass),
    .parity_odd (parity_odd_nx),
    .ovr_en     (ovr_en),
    .ovr_sym    (ovr_sym)
  );

  zs_pulse_former u_former (
    .clk           (edge_clk),
    .rst_n         (rst_n),
    .adv           (adv),
    .out_ready     (out_ready),
    .leave         (leave),
    .parity_odd_nx (parity_odd_nx),
    .out_valid     (out_valid),
    .out_pos       (out_pos),
    .out_neg       (out_neg)
  );

endmodule

// File: rtl/zs_enc_checker.sv
module zs_enc_checker #(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_mode,
  input logic       enc_bypass,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_pos,
  input logic       out_neg
);

  logic       xfer;
  logic [3:0] zrun;
  logic [3:0] zlim;
  logic       seen_pulse;

  assign xfer = out_valid && out_ready;
  assign zlim = (line_mode == 2'b01) ? 4'(LONG_RUN - 1) : 4'(SHORT_RUN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun       <= '0;
      seen_pulse <= 1'b0;
    end else if (xfer) begin
      if (out_pos || out_neg) zrun <= '0;
      else if (zrun != 4'hF)  zrun <= zrun + 4'd1;
      if (out_pos || out_neg) seen_pulse <= 1'b1;
    end
  end

  // R11: zeros delivered in a row stay below the substitution length
  assert_zero_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !enc_bypass && !out_pos && !out_neg |-> zrun < zlim);

  // R2: first pulse after reset is positive
  assert_first_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !enc_bypass && !seen_pulse && (out_pos || out_neg) |-> out_pos);

  // R2: an encoded symbol never drives both rails
  assert_one_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !enc_bypass |-> !(out_pos && out_neg));

  // R9: a stalled symbol is held unchanged
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_pos, out_neg}));

  // R8: taken symbol without a new input leaves the output empty
  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

endmodule

bind b3zs_hdb3_encoder zs_enc_checker #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_chk (
  .clk        (edge_clk),
  .rst_n      (rst_n),
  .line_mode  (line_mode),
  .enc_bypass (enc_bypass),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pos    (out_pos),
  .out_neg    (out_neg)
);

// File: tb/b3zs_hdb3_encoder_tb.sv
`timescale 1ns/1ps
module b3zs_hdb3_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_mode = 2'b00;
  logic       enc_bypass = 1'b0;
  logic       in_valid = 1'b0;
  logic       tx_data = 1'b0;
  logic       tx_aux = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_pos, out_neg;
  logic       n_in_ready, n_valid, n_pos, n_neg;
  logic       one = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  b3zs_hdb3_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .enc_bypass(enc_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .tx_data(tx_data), .tx_aux(tx_aux),
    .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos), .out_neg(out_neg));

  b3zs_hdb3_encoder #(.TX_CLK_INV(1'b1)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .enc_bypass(enc_bypass),
    .in_valid(in_valid), .in_ready(n_in_ready), .tx_data(tx_data), .tx_aux(tx_aux),
    .out_valid(n_valid), .out_ready(one), .out_pos(n_pos), .out_neg(n_neg));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  bit nmon_en = 1'b0;
  bit stall_mode = 1'b0;
  int sc = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag = "";
  bit seq_d[$];
  bit seq_a[$];
  logic [1:0] exp_q[$];
  logic [1:0] exp_nq[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic add_pat(input string s);
    for (int i = 0; i < s.len(); i++) begin
      seq_d.push_back(s[i] == "1");
      seq_a.push_back(rnd());
    end
  endtask

  task automatic add_rand(input int n, input bit dense);
    for (int i = 0; i < n; i++) begin
      bit a, b;
      a = rnd(); b = rnd();
      seq_d.push_back(dense ? a : (a & b));
      seq_a.push_back(rnd());
    end
  endtask

  // Independent reference: greedy zero-run substitution over the whole stream.
  task automatic build_expect(input bit hdb, input bit byp, input bit to_neg);
    int n, L, i;
    bit lp, par, run;
    logic [1:0] sym[$];
    n = seq_d.size(); L = hdb ? 4 : 3; lp = 1'b0; par = 1'b0; i = 0;
    while (i < n) begin
      if (byp) begin
        sym.push_back({seq_d[i], seq_a[i]}); i++;
      end else begin
        run = (i + L <= n);
        for (int k = 0; k < L; k++) if (run && seq_d[i+k]) run = 1'b0;
        if (run) begin
          if (par) begin
            for (int k = 0; k < L-1; k++) sym.push_back(2'b00);
            sym.push_back(lp ? 2'b10 : 2'b01);
          end else begin
            lp = ~lp;
            sym.push_back(lp ? 2'b10 : 2'b01);
            for (int k = 0; k < L-2; k++) sym.push_back(2'b00);
            sym.push_back(lp ? 2'b10 : 2'b01);
          end
          par = 1'b0; i += L;
        end else if (seq_d[i]) begin
          lp = ~lp; par = ~par;
          sym.push_back(lp ? 2'b10 : 2'b01); i++;
        end else begin
          sym.push_back(2'b00); i++;
        end
      end
    end
    foreach (sym[j]) begin
      if (to_neg) exp_nq.push_back(sym[j]);
      else        exp_q.push_back(sym[j]);
    end
  endtask

  // out_ready pattern, updated 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #3;
      sc++;
      out_ready = stall_mode ? ((sc % 3) != 0) : 1'b1;
    end
  end

  // Scoreboard monitor: sample half a period before the taking edge
  always @(negedge clk) begin
    if (mon_en && rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected symbol"}, {out_pos, out_neg}, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check({out_pos, out_neg} == e, cur_tag, {out_pos, out_neg}, e);
      end
    end
  end

  // Monitor for the falling-edge instance (its symbols are taken at falling edges)
  initial begin
    forever begin
      @(posedge clk); #8;
      if (nmon_en && rst_n && n_valid) begin
        if (exp_nq.size() == 0) begin
          check(1'b0, "R10 unexpected symbol", {n_pos, n_neg}, 0);
        end else begin
          logic [1:0] e;
          e = exp_nq.pop_front();
          check({n_pos, n_neg} == e, "R10 falling-edge stream", {n_pos, n_neg}, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic send(input bit d, input bit a, input bit gap);
    bit acc;
    if (gap) begin
      in_valid = 1'b0;
      tick();
    end
    tx_data = d; tx_aux = a; in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = in_ready;
      tick();
    end
    in_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] mode, input bit byp);
    rst_n = 1'b0;
    in_valid = 1'b0;
    stall_mode = 1'b0;
    line_mode = mode;
    enc_bypass = byp;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic run_case(input string tag, input logic [1:0] mode, input bit byp,
                          input bit stall, input bit gaps);
    int L;
    L = (mode == 2'b01) ? 4 : 3;
    do_reset(mode, byp);
    exp_q.delete();
    build_expect(mode == 2'b01, byp, 1'b0);
    cur_tag = tag;
    stall_mode = stall;
    mon_en = 1'b1;
    foreach (seq_d[i]) send(seq_d[i], seq_a[i], gaps && ((i % 5) == 2));
    stall_mode = 1'b0;
    repeat (4) tick();
    mon_en = 1'b0;
    // R8: exactly L symbols remain inside the pipeline
    check(exp_q.size() == L, {tag, " R8 symbols held back"}, exp_q.size(), L);
    seq_d.delete(); seq_a.delete();
  endtask

  initial begin
    // R1: reset state
    do_reset(2'b00, 1'b0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check({out_pos, out_neg} == 2'b00, "R1 rails after reset", {out_pos, out_neg}, 0);

    add_pat("1000110000001010000000001101000100");
    add_rand(60, 1'b0);
    run_case("R2/R3 DS3 B3ZS", 2'b00, 1'b0, 1'b0, 1'b0);

    add_rand(70, 1'b0);
    run_case("R3 STS-1 B3ZS", 2'b10, 1'b0, 1'b0, 1'b1);

    add_pat("0001000011000000");
    add_rand(30, 1'b0);
    run_case("R3 mode 11 B3ZS", 2'b11, 1'b0, 1'b0, 1'b0);

    add_pat("10000100001000000001100000000100000");
    add_rand(70, 1'b0);
    run_case("R4 E3 HDB3", 2'b01, 1'b0, 1'b0, 1'b0);

    add_pat("000000000000000000000000");
    run_case("R5 E3 all zeros", 2'b01, 1'b0, 1'b0, 1'b0);

    add_pat("10000000000000000001");
    run_case("R5 DS3 all zeros", 2'b00, 1'b0, 1'b0, 1'b0);

    add_rand(50, 1'b1);
    run_case("R6 aux ignored", 2'b00, 1'b0, 1'b0, 1'b0);

    add_rand(40, 1'b1);
    run_case("R7 bypass E3", 2'b01, 1'b1, 1'b0, 1'b0);

    add_rand(40, 1'b1);
    run_case("R7 bypass DS3", 2'b00, 1'b1, 1'b0, 1'b1);

    add_rand(80, 1'b0);
    run_case("R9 back-pressure HDB3", 2'b01, 1'b0, 1'b1, 1'b1);

    add_rand(80, 1'b0);
    run_case("R9 back-pressure B3ZS", 2'b10, 1'b0, 1'b1, 1'b0);

    // R8: direct latency probe, B3ZS
    do_reset(2'b00, 1'b0);
    repeat (3) send(1'b1, 1'b0, 1'b0);
    check(out_valid == 1'b0, "R8 B3ZS empty after 3 beats", out_valid, 0);
    send(1'b1, 1'b0, 1'b0);
    check(out_valid == 1'b1, "R8 B3ZS valid after 4th beat", out_valid, 1);
    check({out_pos, out_neg} == 2'b10, "R2 first mark positive", {out_pos, out_neg}, 2'b10);
    tick();
    check(out_valid == 1'b0, "R8 no output without input", out_valid, 0);

    // R8: direct latency probe, HDB3
    do_reset(2'b01, 1'b0);
    repeat (4) send(1'b1, 1'b0, 1'b0);
    check(out_valid == 1'b0, "R8 HDB3 empty after 4 beats", out_valid, 0);
    send(1'b1, 1'b0, 1'b0);
    check(out_valid == 1'b1, "R8 HDB3 valid after 5th beat", out_valid, 1);

    // R10: falling-edge variant
    do_reset(2'b01, 1'b0);
    add_pat("1100001000000001");
    add_rand(40, 1'b0);
    exp_nq.delete();
    exp_q.delete();
    build_expect(1'b1, 1'b0, 1'b1);
    nmon_en = 1'b1;
    fork
      begin
        @(posedge n_valid);
        check(($time % 20) == 0, "R10 update on falling edge", $time % 20, 0);
        check(out_valid == 1'b0, "R10 ahead of rising-edge copy", out_valid, 0);
      end
    join_none
    foreach (seq_d[i]) send(seq_d[i], seq_a[i], 1'b0);
    repeat (4) tick();
    nmon_en = 1'b0;
    check(exp_nq.size() == 4, "R10 symbols held back", exp_nq.size(), 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule